// File: doc/BRIEF.md
# Banked Register-File Data Memory

This block is the byte-wide data store of a small 8-bit controller core. It holds 4096 bytes behind a 12-bit effective address. Each access forms that address in one of three ways: from a 4-bit bank register joined to an 8-bit operand, from a fixed virtual bank that is the same whatever bank is selected, or from a pointer register. The core drives one access port. Writes take effect at the clock edge and reads are combinational.

The top 128 bytes of the map form the special-function window. Three I/O ports live there, each with an output latch and a direction register. The direction register controls the port's pad enables. Every other address in the window reads as zero, and writes to it are discarded. The area below the window is plain RAM with no reset. The bank register and the pointer are loaded through their own strobes, apart from the data port.

Top module: `bankmem_top`

## Requirements
- R1: With mode 2'b00 (banked), the effective address is {bank register, operand}. The same operand under different bank values reaches different bytes.
- R2: With mode 2'b01 (access), operands 0x00–0x7F reach addresses 0x000–0x07F and operands 0x80–0xFF reach 0xF80–0xFFF, whatever the bank register holds.
- R3: With mode[1] = 1 (indirect), the effective address is the low 12 bits of the 16-bit pointer, and pointer bits 15:12 are ignored. Consecutive pointer values cross bank boundaries with no gap.
- R4: A write to RAM (addresses below 0xF80) is stored at the rising edge. A read of an address returns the old byte during the cycle in which that address is written, and the new byte afterwards.
- R5: The port output latches sit at 0xF80 (A), 0xF81 (B) and 0xF82 (C). The direction registers sit at 0xF92 (A), 0xF93 (B) and 0xF94 (C). Port n occupies pin bits [8n+7:8n].
- R6: A direction bit of 0 makes the pad enable 1 and puts the latch bit on the pad output. A direction bit of 1 makes the pad enable 0. The pads change at the edge that stores the write.
- R7: A read of a port data address returns pin_in for bits whose direction is 1 and the latch for bits whose direction is 0. A read of a direction address returns the direction register.
- R8: Reset sets every direction register to 0xFF and clears the latches, the bank register and the pointer.
- R9: bsr_we or ptr_we loads the bank register or the pointer at the rising edge. An access in that same cycle still uses the old value.
- R10: Addresses in 0xF80–0xFFF other than the six port registers read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bsr_we | input | 1 | Load strobe for the bank register |
| bsr_wdata | input | 4 | New bank value |
| ptr_we | input | 1 | Load strobe for the pointer |
| ptr_wdata | input | 16 | New pointer value |
| mode | input | 2 | Addressing mode: 00 banked, 01 access, 1x indirect |
| operand | input | 8 | Operand byte from the instruction |
| we | input | 1 | Write strobe for the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 24 | Sampled pad inputs, ports A..C |
| pin_out | output | 24 | Pad output values (the latches) |
| pin_oe | output | 24 | Pad output enables, 1 means driven |

## Verification
rdata is combinational, so it is due in the same cycle as mode and operand. The bench drives inputs on the falling edge and samples one nanosecond later. Writes, bank loads, pointer loads and pad changes appear only after the next rising edge. The bench therefore reads their effects in the cycle after the strobe. It deliberately samples once inside the strobe cycle, to confirm that the old byte and the old bank are still visible there.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;
    typedef enum logic [1:0] {
        AM_BANKED   = 2'b00,
        AM_ACCESS   = 2'b01,
        AM_INDIRECT = 2'b10,
        AM_IND_ALT  = 2'b11
    } amode_e;
endpackage

// File: rtl/bankmem_agen.sv
module bankmem_agen
    import bankmem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 4,
    parameter int PTR_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bsr_we,
    input  logic [BANK_W-1:0]        bsr_wdata,
    input  logic                     ptr_we,
    input  logic [PTR_W-1:0]         ptr_wdata,
    input  logic [1:0]               mode,
    input  logic [ADDR_W-BANK_W-1:0] operand,
    output logic [ADDR_W-1:0]        ea
);
    localparam int OP_W = ADDR_W - BANK_W;

    logic [BANK_W-1:0] bsr_q;
    logic [PTR_W-1:0]  ptr_q;
    amode_e            am;

    assign am = amode_e'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsr_q <= '0;
            ptr_q <= '0;
        end else begin
            if (bsr_we) bsr_q <= bsr_wdata;
            if (ptr_we) ptr_q <= ptr_wdata;
        end
    end

    always_comb begin
        unique case (am)
            AM_BANKED:  ea = {bsr_q, operand};
            AM_ACCESS:  ea = operand[OP_W-1] ? {{BANK_W{1'b1}}, operand}
                                             : {{BANK_W{1'b0}}, operand};
            default:    ea = ptr_q[ADDR_W-1:0];
        endcase
    end

    // R2
    access_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (am == AM_ACCESS) |-> (ea[ADDR_W-1 -: BANK_W] == (operand[OP_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}})));

    // R9
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bsr_we) && am == AM_BANKED) |-> (ea[ADDR_W-1 -: BANK_W] == $past(bsr_wdata)));

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ptr_we) && mode[1]) |-> (ea == $past(ptr_wdata[ADDR_W-1:0])));
endmodule

// File: rtl/bankmem_gpr.sv
module bankmem_gpr #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3968
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

    // R4
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en ##1 (addr == $past(addr))) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/bankmem_sfr.sv
module bankmem_sfr #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int NUM_PORTS = 3,
    parameter int DATA_BASE = 'hF80,
    parameter int DIR_BASE  = 'hF92
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    input  logic [NUM_PORTS*DATA_W-1:0]   pin_in,
    output logic [NUM_PORTS*DATA_W-1:0]   pin_out,
    output logic [NUM_PORTS*DATA_W-1:0]   pin_oe
);
    logic [DATA_W-1:0] lat_q [NUM_PORTS];
    logic [DATA_W-1:0] dir_q [NUM_PORTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                lat_q[i] <= '0;
                dir_q[i] <= '1;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (addr == ADDR_W'(DATA_BASE + i)) lat_q[i] <= wdata;
                if (addr == ADDR_W'(DIR_BASE + i))  dir_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (addr == ADDR_W'(DATA_BASE + i))
                rdata = (dir_q[i] & pin_in[i*DATA_W +: DATA_W]) | (~dir_q[i] & lat_q[i]);
            if (addr == ADDR_W'(DIR_BASE + i))
                rdata = dir_q[i];
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign pin_out[g*DATA_W +: DATA_W] = lat_q[g];
        assign pin_oe[g*DATA_W +: DATA_W]  = ~dir_q[g];

        // R6
        dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(DIR_BASE + g)) |=> (pin_oe[g*DATA_W +: DATA_W] == ~$past(wdata)));

        // R5
        latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(DATA_BASE + g)) |=> (pin_out[g*DATA_W +: DATA_W] == $past(wdata)));
    end
endmodule

// File: rtl/bankmem_top.sv
module bankmem_top #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 12,
    parameter int BANK_W    = 4,
    parameter int PTR_W     = 16,
    parameter int NUM_PORTS = 3,
    parameter int SFR_SPAN  = 128,
    parameter int PORT_DATA_BASE = 'hF80,
    parameter int PORT_DIR_BASE  = 'hF92
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bsr_we,
    input  logic [BANK_W-1:0]           bsr_wdata,
    input  logic                        ptr_we,
    input  logic [PTR_W-1:0]            ptr_wdata,
    input  logic [1:0]                  mode,
    input  logic [ADDR_W-BANK_W-1:0]    operand,
    input  logic                        we,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic [NUM_PORTS*DATA_W-1:0] pin_in,
    output logic [NUM_PORTS*DATA_W-1:0] pin_out,
    output logic [NUM_PORTS*DATA_W-1:0] pin_oe
);
    localparam int SFR_BASE  = (1 << ADDR_W) - SFR_SPAN;
    localparam int GPR_DEPTH = SFR_BASE;

    logic [ADDR_W-1:0] ea;
    logic              sfr_sel;
    logic [DATA_W-1:0] gpr_rdata;
    logic [DATA_W-1:0] sfr_rdata;

    bankmem_agen #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) agen_i (
        .clk(clk), .rst_n(rst_n),
        .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .mode(mode), .operand(operand), .ea(ea)
    );

    assign sfr_sel = (ea >= ADDR_W'(SFR_BASE));

    bankmem_gpr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(GPR_DEPTH)) gpr_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we && !sfr_sel),
        .addr(ea), .wdata(wdata), .rdata(gpr_rdata)
    );

    bankmem_sfr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS),
        .DATA_BASE(PORT_DATA_BASE), .DIR_BASE(PORT_DIR_BASE)
    ) sfr_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we && sfr_sel),
        .addr(ea), .wdata(wdata), .rdata(sfr_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign rdata = sfr_sel ? sfr_rdata : gpr_rdata;
endmodule

// File: tb/bankmem_tb_top.sv
module bankmem_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsr_we = 1'b0;
    logic [3:0]  bsr_wdata = '0;
    logic        ptr_we = 1'b0;
    logic [15:0] ptr_wdata = '0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  operand = '0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [1:0] BNK = 2'b00, ACC = 2'b01, IND = 2'b10;

    always #10 clk = ~clk;

    bankmem_top dut_i (
        .clk(clk), .rst_n(rst_n), .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .mode(mode), .operand(operand),
        .we(we), .wdata(wdata), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [7:0] op, input logic [7:0] d);
        @(negedge clk); mode = m; operand = op; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] m, input logic [7:0] op, output logic [7:0] v);
        @(negedge clk); mode = m; operand = op; we = 1'b0;
        #1 v = rdata;
    endtask

    task automatic set_bsr(input logic [3:0] b);
        @(negedge clk); bsr_we = 1'b1; bsr_wdata = b;
        @(negedge clk); bsr_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = p;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R8 pin_oe after reset", pin_oe, 24'h0);
        chk("R8 pin_out after reset", pin_out, 24'h0);
        rd(ACC, 8'h94, v); chk("R8 port C direction reset", v, 8'hFF);
        wr(BNK, 8'h10, 8'h5A);
        rd(ACC, 8'h10, v); chk("R8 bank register cleared", v, 8'h5A);
    endtask

    task automatic t_banked();
        logic [7:0] v;
        set_bsr(4'h2); wr(BNK, 8'h40, 8'hA1);
        set_bsr(4'h3); wr(BNK, 8'h40, 8'hB2);
        set_bsr(4'h2); rd(BNK, 8'h40, v); chk("R1 bank 2 byte", v, 8'hA1);
        @(negedge clk); bsr_we = 1'b1; bsr_wdata = 4'h3; mode = BNK; operand = 8'h40;
        #1 chk("R9 old bank in load cycle", rdata, 8'hA1);
        @(negedge clk); bsr_we = 1'b0;
        #1 chk("R9 new bank after load", rdata, 8'hB2);
        set_ptr(16'h0240); rd(IND, 8'h00, v); chk("R1 bank 2 via pointer", v, 8'hA1);
    endtask

    task automatic t_access();
        logic [7:0] v;
        set_bsr(4'h5); wr(ACC, 8'h20, 8'h3C);
        set_bsr(4'h0); rd(BNK, 8'h20, v); chk("R2 low half maps to bank 0", v, 8'h3C);
        set_bsr(4'h5); wr(ACC, 8'h93, 8'h0F);
        chk("R2 high half reaches port B direction", pin_oe[15:8], 32'hF0);
        set_bsr(4'hF); rd(BNK, 8'h93, v); chk("R2 high half maps to bank 15", v, 8'h0F);
        wr(ACC, 8'h93, 8'hFF);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        set_ptr(16'h01FF); wr(IND, 8'h00, 8'h11);
        set_ptr(16'h0200); wr(IND, 8'h00, 8'h22);
        set_bsr(4'h1); rd(BNK, 8'hFF, v); chk("R3 last byte of bank 1", v, 8'h11);
        set_bsr(4'h2); rd(BNK, 8'h00, v); chk("R3 first byte of bank 2", v, 8'h22);
        set_ptr(16'hA1FF); rd(IND, 8'h00, v); chk("R3 pointer upper bits ignored", v, 8'h11);
    endtask

    task automatic t_port_c();
        wr(ACC, 8'h94, 8'h00);
        wr(ACC, 8'h82, 8'h55);
        chk("R6 port C enables", pin_oe[23:16], 32'hFF);
        chk("R5 port C drives 0x55", pin_out[23:16], 32'h55);
    endtask

    task automatic t_port_mix();
        logic [7:0] v;
        pin_in = 24'hA30000;
        wr(ACC, 8'h94, 8'hF0);
        chk("R6 mixed enables", pin_oe[23:16], 32'h0F);
        rd(ACC, 8'h82, v); chk("R7 mixed port read", v, 8'hA5);
        rd(ACC, 8'h94, v); chk("R7 direction readback", v, 8'hF0);
    endtask

    task automatic t_port_a();
        wr(ACC, 8'h80, 8'h99);
        wr(ACC, 8'h92, 8'h00);
        chk("R5 port A latch", pin_out[7:0], 32'h99);
        chk("R5 port A enables", pin_oe[7:0], 32'hFF);
        chk("R5 port B untouched", pin_oe[15:8], 32'h00);
    endtask

    task automatic t_same_cycle();
        set_bsr(4'h7); wr(BNK, 8'h33, 8'h44);
        @(negedge clk); mode = BNK; operand = 8'h33; wdata = 8'hC8; we = 1'b1;
        #1 chk("R4 old byte during write", rdata, 8'h44);
        @(negedge clk); we = 1'b0;
        #1 chk("R4 new byte after write", rdata, 8'hC8);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(ACC, 8'hA0, 8'h77);
        rd(ACC, 8'hA0, v); chk("R10 hole reads zero", v, 8'h00);
        chk("R10 pads unchanged", pin_out, 24'h550099);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_banked();
        t_access();
        t_indirect();
        t_port_c();
        t_port_mix();
        t_port_a();
        t_same_cycle();
        t_unmapped();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule